// File: doc/BRIEF.md
# Biphase Mark Transmit Half-Bit Serializer

This block drives the transmit side of a single-wire Biphase Mark Coded link. Once `start` is pulsed it raises the line-driver enable and sends a fixed alternating preamble. It then takes 5-bit line symbols, which are already 4b5b coded, from an upstream producer. Each symbol becomes ten half-bit levels, sent least significant data bit first. The block finishes the packet with a closing edge so the wire always rests low. Every half-bit holds for `CLK_PER_HB` clock cycles, so the half-bit rate is the clock rate divided by that value. The nominal setting is 600 kHz, which is twice the 300 kbit/s data rate.

Line polarity stays continuous across symbol boundaries. Each symbol is first expanded as if the line had been low. The result is then inverted as a whole when the previous half-bit was high. The top bit of the result becomes the reference level for the next symbol. The producer sees a just-in-time handshake: `sym_ready` rises for one cycle at the end of the current unit. If `sym_valid` is low in that cycle, the packet is cut short and the underrun flag is raised.

Top module: `bmc_tx_serializer`

## Requirements
- R1: After reset, `line_out`, `line_oe`, `sym_ready` and `underrun` are all 0.
- R2: Each half-bit level holds for exactly `CLK_PER_HB` clock cycles. The first preamble half-bit appears on the clock edge that samples `start` high while idle.
- R3: The preamble is `32*PRE_REPEAT` half-bits (128 by default). It is the 32-bit word `PRE_WORD` (default 0xB4B4B4B4), sent bit 0 first and repeated.
- R4: Each symbol bit, taken from bit 0 upward, gives two half-bits. The first half-bit inverts the previous level. The second half-bit inverts it again if the data bit is 1 and repeats it if the data bit is 0.
- R5: Polarity is continuous. The first symbol's first half-bit is the inverse of the preamble's final half-bit (high). Every later symbol starts by inverting the last half-bit of the symbol before it.
- R6: `sym_ready` is high only in the final clock cycle of the preamble's last half-bit, or of the last half-bit of a symbol not flagged with `sym_last`. A symbol is taken in a cycle where both `sym_ready` and `sym_valid` are high.
- R7: After the symbol flagged `sym_last`, two closing half-bits follow. They are high then low if the line ended low, or low then low if it ended high.
- R8: `line_oe` is high from the first preamble half-bit to the end of the second closing half-bit. After that, `line_oe` and `line_out` both return to 0.
- R9: If `sym_valid` is low in a cycle where `sym_ready` is high, `underrun` rises on the next edge and the closing half-bits follow at once. `underrun` stays set until the next accepted `start`.
- R10: A `start` pulse while `line_oe` is high has no effect on the waveform.
- R11: `line_out` is 0 whenever `line_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (acted on only while idle) |
| sym_valid | input | 1 | Producer has a symbol on `sym_data` |
| sym_data | input | SYM_W | Line symbol, bit 0 sent first |
| sym_last | input | 1 | Marks the final symbol of the packet |
| sym_ready | output | 1 | Symbol is taken this cycle if valid |
| line_out | output | 1 | Half-bit line level |
| line_oe | output | 1 | Enable for the line driver |
| underrun | output | 1 | Packet was cut short for lack of a symbol |

## Verification
The bench builds the block with `CLK_PER_HB` set to 3 and the default 128-half-bit preamble. With that setting a full packet lasts only a few hundred cycles, and each half-bit still has a distinct first, middle and last cycle, so a level that changes one cycle early or late is caught. Symbol choices put the line low or high before the closing edge, so both closing patterns are exercised. A withheld symbol reaches the underrun path, both right after the preamble and in mid-packet.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_SYM  = 2'd2,
        ST_TRL  = 2'd3
    } bmc_st_e;
endpackage

// File: rtl/bmc_tx_slot_timer.sv
module bmc_tx_slot_timer #(
    parameter int CLK_PER_HB = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic slot_end
);
    localparam int CW = $clog2(CLK_PER_HB + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        slot_end = run && (cnt_q == CW'(CLK_PER_HB - 1));
        if (!run || slot_end) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bmc_tx_expand.sv
module bmc_tx_expand #(
    parameter int SYM_W = 5
) (
    input  logic [SYM_W-1:0]   sym_i,
    input  logic               prev_lvl_i,
    output logic [2*SYM_W-1:0] hb_o
);
    logic [2*SYM_W-1:0] raw;

    // Expansion assumes the line was low before the symbol; the mask fixes polarity.
    always_comb begin
        logic lvl;
        lvl = 1'b0;
        for (int i = 0; i < SYM_W; i++) begin
            lvl          = ~lvl;
            raw[2*i]     = lvl;
            if (sym_i[i]) lvl = ~lvl;
            raw[2*i+1]   = lvl;
        end
        hb_o = raw ^ {(2*SYM_W){prev_lvl_i}};
    end
endmodule

// File: rtl/bmc_tx_serializer.sv
module bmc_tx_serializer
    import bmc_tx_pkg::*;
#(
    parameter int          CLK_PER_HB = 80,
    parameter int          SYM_W      = 5,
    parameter int          PRE_REPEAT = 4,
    parameter logic [31:0] PRE_WORD   = 32'hB4B4_B4B4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             sym_last,
    output logic             sym_ready,
    output logic             line_out,
    output logic             line_oe,
    output logic             underrun
);
    localparam int PRE_HB     = 32 * PRE_REPEAT;
    localparam int HB_PER_SYM = 2 * SYM_W;
    localparam int SH_IW      = $clog2(HB_PER_SYM);
    localparam int PRE_IW     = $clog2(PRE_HB);
    localparam int IDX_W      = (PRE_IW > SH_IW) ? PRE_IW : SH_IW;

    typedef struct packed {
        bmc_st_e               st;
        logic [IDX_W-1:0]      idx;
        logic [HB_PER_SYM-1:0] shf;
        logic                  lvl;
        logic                  fin;
        logic                  line;
        logic                  oe;
        logic                  unr;
    } reg_t;

    reg_t q, d;

    logic                  slot_end;
    logic [HB_PER_SYM-1:0] exp_hb;
    logic [SH_IW-1:0]      sh_nx;
    logic [4:0]            pre_nx;
    logic                  rdy;

    bmc_tx_slot_timer #(.CLK_PER_HB(CLK_PER_HB)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.st != ST_IDLE),
        .slot_end (slot_end)
    );

    bmc_tx_expand #(.SYM_W(SYM_W)) u_expand (
        .sym_i      (sym_data),
        .prev_lvl_i (q.lvl),
        .hb_o       (exp_hb)
    );

    assign sh_nx  = q.idx[SH_IW-1:0] + 1'b1;
    assign pre_nx = q.idx[4:0] + 1'b1;

    always_comb begin
        logic fetch;
        logic close;
        d     = q;
        rdy   = 1'b0;
        fetch = 1'b0;
        close = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                d.line = 1'b0;
                d.oe   = 1'b0;
                if (start) begin
                    d.st   = ST_PRE;
                    d.idx  = '0;
                    d.line = PRE_WORD[0];
                    d.oe   = 1'b1;
                    d.unr  = 1'b0;
                    d.lvl  = 1'b1;
                end
            end
            ST_PRE: begin
                if (slot_end) begin
                    if (q.idx == IDX_W'(PRE_HB - 1)) begin
                        fetch = 1'b1;
                    end else begin
                        d.idx  = q.idx + 1'b1;
                        d.line = PRE_WORD[pre_nx];
                    end
                end
            end
            ST_SYM: begin
                if (slot_end) begin
                    if (q.idx == IDX_W'(HB_PER_SYM - 1)) begin
                        if (q.fin) close = 1'b1;
                        else       fetch = 1'b1;
                    end else begin
                        d.idx  = q.idx + 1'b1;
                        d.line = q.shf[sh_nx];
                    end
                end
            end
            ST_TRL: begin
                if (slot_end) begin
                    if (q.idx == '0) begin
                        d.idx  = IDX_W'(1);
                        d.line = 1'b0;
                    end else begin
                        d.st   = ST_IDLE;
                        d.line = 1'b0;
                        d.oe   = 1'b0;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (fetch) begin
            rdy = 1'b1;
            if (sym_valid) begin
                d.st   = ST_SYM;
                d.idx  = '0;
                d.shf  = exp_hb;
                d.line = exp_hb[0];
                d.lvl  = exp_hb[HB_PER_SYM-1];
                d.fin  = sym_last;
            end else begin
                d.unr = 1'b1;
                close = 1'b1;
            end
        end

        if (close) begin
            d.st   = ST_TRL;
            d.idx  = '0;
            d.line = ~q.lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, idx: '0, shf: '0, lvl: 1'b0, fin: 1'b0,
                   line: 1'b0, oe: 1'b0, unr: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sym_ready = rdy;
    assign line_out  = q.line;
    assign line_oe   = q.oe;
    assign underrun  = q.unr;
endmodule

// File: rtl/bmc_tx_chk.sv
module bmc_tx_chk #(
    parameter int CLK_PER_HB = 80
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic sym_valid,
    input logic sym_ready,
    input logic line_out,
    input logic line_oe,
    input logic underrun
);
    localparam int PW = $clog2(CLK_PER_HB + 1);
    logic [PW-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !line_oe)            ph_q <= '0;
        else if (ph_q == PW'(CLK_PER_HB - 1)) ph_q <= '0;
        else                               ph_q <= ph_q + 1'b1;
    end

    assert_idle_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> !line_out);

    assert_ready_in_pkt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready |-> line_oe);

    assert_oe_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> $past(start));

    assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(sym_ready && !sym_valid));

    assert_end_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_oe) |-> !$past(line_out));

    assert_slot_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && $past(line_oe) && (line_out != $past(line_out))) |-> (ph_q == '0));
endmodule

bind bmc_tx_serializer bmc_tx_chk #(.CLK_PER_HB(CLK_PER_HB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .line_out  (line_out),
    .line_oe   (line_oe),
    .underrun  (underrun)
);

// File: tb/tb_bmc_tx_serializer.sv
`timescale 1ns/1ps
module tb_bmc_tx_serializer;
    localparam int HB  = 3;
    localparam int PRE = 128;
    localparam logic [31:0] PW = 32'hB4B4_B4B4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       sym_valid = 1'b0;
    logic [4:0] sym_data = '0;
    logic       sym_last = 1'b0;
    logic       sym_ready, line_out, line_oe, underrun;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [4:0] syms [16];

    always #2 clk = ~clk;

    bmc_tx_serializer #(.CLK_PER_HB(HB)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sym_valid(sym_valid),
        .sym_data(sym_data), .sym_last(sym_last), .sym_ready(sym_ready),
        .line_out(line_out), .line_oe(line_oe), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
        end
    endtask

    // n symbols; gap >= 0 withholds symbol number gap; glitch >= 0 pulses start at that cycle
    task automatic run_pkt(input int n, input int gap, input int glitch);
        bit exp_hb[$];
        bit lvl;
        int nsent, fetches, total, sidx;
        bit xfer;
        exp_hb.delete();
        for (int i = 0; i < PRE; i++) exp_hb.push_back(PW[i % 32]);
        nsent   = (gap >= 0) ? gap : n;
        fetches = (gap >= 0) ? gap + 1 : n;
        lvl = 1'b1;
        for (int s = 0; s < nsent; s++) begin
            for (int b = 0; b < 5; b++) begin
                lvl = ~lvl; exp_hb.push_back(lvl);
                if (syms[s][b]) lvl = ~lvl;
                exp_hb.push_back(lvl);
            end
        end
        if (!lvl) begin exp_hb.push_back(1'b1); exp_hb.push_back(1'b0); end
        else      begin exp_hb.push_back(1'b0); exp_hb.push_back(1'b0); end
        total = exp_hb.size();

        sidx = 0; xfer = 0;
        @(negedge clk);
        sym_valid = (sidx < n) && (sidx != gap);
        sym_data  = syms[0];
        sym_last  = (n == 1);
        start = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= total * HB; k++) begin
            int  h;
            bit  e_oe, e_line, e_rdy;
            string tg;
            @(negedge clk);
            start = (k == glitch);
            if (xfer) sidx++;
            sym_valid = (sidx < n) && (sidx != gap);
            sym_data  = syms[sidx % 16];
            sym_last  = (sidx == n - 1);
            h      = k / HB;
            e_oe   = (k < total * HB);
            e_line = e_oe ? exp_hb[h] : 1'b0;
            e_rdy  = e_oe && (k % HB == HB - 1) && (h >= PRE - 1) &&
                     ((h - (PRE - 1)) % 10 == 0) && ((h - (PRE - 1)) / 10 < fetches);
            if (glitch >= 0 && k >= glitch)  tg = "R10";
            else if (!e_oe)                  tg = "R11";
            else if (h < PRE)                tg = (k % HB != 0) ? "R2" : "R3";
            else if (h == PRE)               tg = "R5";
            else if (h >= total - 2)         tg = "R7";
            else                             tg = "R4";
            chk(line_out == e_line, tg, line_out, e_line);
            chk(line_oe == e_oe, "R8", line_oe, e_oe);
            chk(sym_ready == e_rdy, "R6", sym_ready, e_rdy);
            xfer = sym_ready && sym_valid;
        end
        chk(underrun == (gap >= 0), "R9", underrun, (gap >= 0));
        sym_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(line_out == 0, "R1", line_out, 0);
        chk(line_oe == 0, "R1", line_oe, 0);
        chk(sym_ready == 0, "R1", sym_ready, 0);
        chk(underrun == 0, "R1", underrun, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R5: mixed symbols, three in a packet
        syms[0] = 5'b10110; syms[1] = 5'b00111; syms[2] = 5'b11001;
        run_pkt(3, -1, -1);
        // R7: single symbol ending low -> closing high, low
        syms[0] = 5'b00000;
        run_pkt(1, -1, -1);
        // R7: single symbol ending high -> closing low, low
        syms[0] = 5'b00001;
        run_pkt(1, -1, -1);
        // R9: underrun right after the preamble
        run_pkt(2, 0, -1);
        // R9: underrun mid packet, then normal packet clears flag
        syms[0] = 5'b11111; syms[1] = 5'b01010; syms[2] = 5'b10101;
        run_pkt(4, 2, -1);
        syms[0] = 5'b01101;
        run_pkt(1, -1, -1);
        // R10: start pulsed in mid packet, long packet
        for (int i = 0; i < 8; i++) syms[i] = 5'((i * 7 + 3) % 32);
        run_pkt(8, -1, 200);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule